// File: doc/BRIEF.md
# Byte-Addressed Serial Memory Target Engine

This block is the bus-facing half of a small two-wire serial memory with 256 byte locations. It runs on a fast system clock and oversamples the raw clock and data lines. From them it detects Start and Stop, collects control, address and data bytes, and acknowledges by pulling the data line low through an open-drain enable. The memory array and the page buffer sit outside the block. The engine reads the array through a one-cycle-latency read port and sends every accepted write byte, with its address, to the page buffer. When the frame closes with a Stop, it raises a single-cycle commit strobe that tells the buffer to program the stored bytes.

The engine holds one byte pointer for both directions. A write frame loads the pointer from its second byte. Reads and writes both advance it, so a read with no address phase picks up where the last access stopped. During a write the pointer moves only inside its 16-byte page. During a read it runs across the whole array and wraps at the top. While the external write cycle is running (`busy`), the engine refuses every control byte, so the master can poll for completion. A protection unit outside the block can refuse single data bytes through `ack_inhibit`.

Top module: `i2c_mem_target`

## Requirements
- R1: Out of reset, `sda_oe`, `wr_valid` and `commit` are low and the pointer is 00h, so a read with no address phase returns location 00h.
- R2: A falling data line while the clock is high is a Start. A rising data line while the clock is high is a Stop. A Start at any point, including in the middle of a frame, restarts control-byte reception.
- R3: A control byte is acknowledged (data held low during the ninth clock) only if its bits [7:4] equal 1010b and its bits [3:1] equal `dev_sel[2:0]`. Bit 0 selects read (1) or write (0). Any other control byte is refused, and the engine then ignores the bus, acknowledging nothing, until the next Start.
- R4: While `busy` is high, a control byte is not acknowledged. A write control byte followed by Stop therefore serves as a completion poll.
- R5: In a write frame, the byte after the control byte loads the pointer and is acknowledged. Each later data byte is acknowledged and presented for one cycle on `wr_valid`, with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R6: If `ack_inhibit` is high when a write data byte completes, that byte is refused, no `wr_valid` is raised, and the array keeps its old contents.
- R7: On a Stop, `commit` pulses for one cycle if at least one data byte was accepted since the last Start. A Start drops the pending commit, so a repeated Start after data produces no commit.
- R8: During a write, only the low 4 bits of the pointer advance, and they wrap within the page. For example, writes starting at 3Eh go to 3Eh, 3Fh, 30h and 31h.
- R9: A read control byte returns the byte at the pointer, MSB first, and advances the pointer. A master ACK fetches the next byte. A master NACK ends the read with the data line released. The pointer wraps from FFh to 00h.
- R10: `sda_oe` changes only while the clock line is low, and no earlier than HOLD_CYC cycles after the clock line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| dev_sel | input | 3 | Strapped chip-select value compared with control bits [3:1] |
| busy | input | 1 | External write cycle in progress; refuse all control bytes |
| ack_inhibit | input | 1 | Refuse the write data byte now completing |
| mem_raddr | output | 8 | Array read address (equals the pointer) |
| mem_rdata | input | 8 | Array read data, one cycle after the address |
| wr_valid | output | 1 | One-cycle strobe: accepted write byte |
| wr_addr | output | 8 | Address of the accepted write byte |
| wr_data | output | 8 | Value of the accepted write byte |
| commit | output | 1 | One-cycle strobe: program the page buffer |

## Verification
The hardest situation to reach from the ports is a refused control byte during the external write cycle. It exists only in the short window after a commit, while the bench's model of the array holds `busy` high. The bench gets there by polling straight after every write frame: the first poll must be refused, and a later poll must be accepted. Pointer continuity is the other subtle point. Random page writes, addressed reads and current-address reads are interleaved, and a bench pointer model checks that every read with no address phase continues from wherever the previous operation left the pointer.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eng_state_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;
  logic            scl_prev;
  logic            sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_raw};
      sda_sh <= {sda_sh[STAGES-1:0], sda_raw};
    end
  end

  assign scl_hi    = scl_sh[STAGES-1];
  assign sda_hi    = sda_sh[STAGES-1];
  assign scl_prev  = scl_sh[STAGES];
  assign sda_prev  = sda_sh[STAGES];
  assign scl_rise  = scl_hi & ~scl_prev;
  assign scl_fall  = ~scl_hi & scl_prev;
  assign start_det = scl_hi & scl_prev & sda_prev & ~sda_hi;
  assign stop_det  = scl_hi & scl_prev & ~sda_prev & sda_hi;
endmodule

// File: rtl/i2cm_sda_hold.sv
module i2cm_sda_hold #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_hi,
  input  logic want,
  output logic oe
);
  localparam int CW = $clog2(HOLD_CYC + 2);

  logic [CW-1:0] cnt, cnt_d;
  logic          oe_d;

  always_comb begin
    cnt_d = cnt;
    oe_d  = oe;
    if (scl_hi) begin
      cnt_d = '0;
    end else if (cnt != CW'(HOLD_CYC)) begin
      cnt_d = cnt + 1'b1;
    end
    if (!scl_hi && cnt == CW'(HOLD_CYC)) begin
      oe_d = want;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      oe  <= 1'b0;
    end else begin
      cnt <= cnt_d;
      oe  <= oe_d;
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cm_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          PAGE_W      = 4,
  parameter logic [3:0]  CTRL_CODE   = 4'b1010,
  parameter int          SYNC_STAGES = 2,
  parameter int          HOLD_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              busy,
  input  logic              ack_inhibit,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit
);
  localparam int BIT_W = 4;
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(8);

  // reset: asserted asynchronously, released synchronously
  logic [1:0] rst_sh;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_n_s = rst_sh[1];

  logic scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eng_state_t        st, st_d;
  logic [BIT_W-1:0]  bitcnt, bitcnt_d;
  logic [7:0]        shreg, shreg_d, txbyte, txbyte_d, byte_in;
  logic [ADDR_W-1:0] ptr, ptr_d, wr_addr_d;
  logic [7:0]        wr_data_d;
  logic              ack_q, ack_d, rd_q, rd_d, pend, pend_d;
  logic              want, want_d, wr_valid_d, commit_d;

  assign byte_in   = {shreg[6:0], sda_hi};
  assign mem_raddr = ptr;

  always_comb begin
    st_d       = st;
    bitcnt_d   = bitcnt;
    shreg_d    = shreg;
    txbyte_d   = txbyte;
    ptr_d      = ptr;
    ack_d      = ack_q;
    rd_d       = rd_q;
    pend_d     = pend;
    want_d     = want;
    wr_valid_d = 1'b0;
    wr_addr_d  = wr_addr;
    wr_data_d  = wr_data;
    commit_d   = 1'b0;
    if (start_det) begin
      st_d     = ST_CTRL;
      bitcnt_d = '0;
      want_d   = 1'b0;
      pend_d   = 1'b0;
    end else if (stop_det) begin
      st_d     = ST_IDLE;
      want_d   = 1'b0;
      commit_d = pend;
      pend_d   = 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt != ACK_SLOT) begin
          shreg_d  = byte_in;
          bitcnt_d = bitcnt + 1'b1;
          if (bitcnt == ACK_SLOT - 1'b1) begin
            ack_d = 1'b0;
            unique case (st)
              ST_CTRL: begin
                if (!busy && byte_in[7:4] == CTRL_CODE && byte_in[3:1] == dev_sel) begin
                  ack_d = 1'b1;
                  rd_d  = byte_in[0];
                end else begin
                  st_d = ST_IDLE;
                end
              end
              ST_ADDR: begin
                ack_d = 1'b1;
                ptr_d = ADDR_W'(byte_in);
              end
              ST_WDATA: begin
                if (!ack_inhibit) begin
                  ack_d      = 1'b1;
                  wr_valid_d = 1'b1;
                  wr_addr_d  = ptr;
                  wr_data_d  = byte_in;
                  pend_d     = 1'b1;
                  ptr_d      = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                end else begin
                  st_d = ST_IDLE;
                end
              end
              default: ack_d = 1'b0;
            endcase
          end
        end else begin
          bitcnt_d = '0;
          unique case (st)
            ST_CTRL: begin
              if (rd_q) begin
                st_d     = ST_RDATA;
                txbyte_d = mem_rdata;
                ptr_d    = ptr + 1'b1;
              end else begin
                st_d = ST_ADDR;
              end
            end
            ST_ADDR: st_d = ST_WDATA;
            ST_RDATA: begin
              if (!sda_hi) begin
                txbyte_d = mem_rdata;
                ptr_d    = ptr + 1'b1;
              end else begin
                st_d = ST_IDLE;
              end
            end
            default: st_d = st;
          endcase
        end
      end
      if (scl_fall) begin
        if (bitcnt == ACK_SLOT)   want_d = (st != ST_RDATA) && ack_q;
        else if (st == ST_RDATA)  want_d = ~txbyte[~bitcnt[2:0]];
        else                      want_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txbyte   <= '0;
      ptr      <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      pend     <= 1'b0;
      want     <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      commit   <= 1'b0;
    end else begin
      st       <= st_d;
      bitcnt   <= bitcnt_d;
      shreg    <= shreg_d;
      txbyte   <= txbyte_d;
      ptr      <= ptr_d;
      ack_q    <= ack_d;
      rd_q     <= rd_d;
      pend     <= pend_d;
      want     <= want_d;
      wr_valid <= wr_valid_d;
      wr_addr  <= wr_addr_d;
      wr_data  <= wr_data_d;
      commit   <= commit_d;
    end
  end

  i2cm_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n_s), .scl_hi(scl_hi), .want(want), .oe(sda_oe)
  );

  // R4: a busy array never lets a frame move past its control byte
  a_r4_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_CTRL && busy && !start_det) |=> (st == ST_CTRL || st == ST_IDLE));
  // R6: a write strobe only follows a data byte received while not inhibited
  a_r6_wr_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |-> $past(st == ST_WDATA && !ack_inhibit));
  // R5: one strobe per byte
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_valid |=> !wr_valid);
  // R7: commit follows a detected Stop
  a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit |-> $past(stop_det));
  // R8: page bits stay fixed while data bytes are accepted
  a_r8_page_fixed: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st == ST_WDATA && $past(st == ST_WDATA))
      |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  // R10: the data drive moves only while the synchronised clock is low
  a_r10_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_hi));
endmodule

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int Q = 10;
  localparam int HOLD = 3;
  localparam int BUSY_CYC = 2000;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] CTRL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] CTRL_R = {4'b1010, CS, 1'b1};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, scl_m, sda_m, busy, ack_inhibit;
  logic       sda_oe, wr_valid, commit;
  logic [7:0] mem_raddr, mem_rdata, wr_addr, wr_data;
  wire        sda_line = sda_m & ~sda_oe;

  i2c_mem_target #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .dev_sel(CS), .busy(busy), .ack_inhibit(ack_inhibit),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  // environment: array, page buffer, write cycle timer, monitors
  logic [7:0] env_mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] pend_d [256];
  logic       pend_v [256];
  int busy_cnt = 0, commit_n = 0, wlog_n = 0, start_n = 0, start_seen = 0;
  int viol_n = 0, low_cnt = 0;
  logic prev_oe = 1'b0;
  logic [7:0] wlog_a [64];
  logic [7:0] wlog_d [64];

  always @(posedge clk) begin
    mem_rdata <= env_mem[mem_raddr];
    if (start_n != start_seen) begin
      start_seen = start_n;
      for (int i = 0; i < 256; i++) pend_v[i] = 1'b0;
    end
    if (wr_valid) begin
      pend_v[wr_addr] = 1'b1;
      pend_d[wr_addr] = wr_data;
      if (wlog_n < 64) begin
        wlog_a[wlog_n] = wr_addr;
        wlog_d[wlog_n] = wr_data;
      end
      wlog_n++;
    end
    if (commit) begin
      commit_n++;
      for (int i = 0; i < 256; i++) if (pend_v[i]) begin
        env_mem[i] = pend_d[i];
        pend_v[i]  = 1'b0;
      end
      busy_cnt = BUSY_CYC;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
    busy <= (busy_cnt != 0);
    if (rst_n && sda_oe != prev_oe && (scl_m || low_cnt < HOLD)) viol_n++;
    prev_oe = sda_oe;
    low_cnt = scl_m ? 0 : low_cnt + 1;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; start_n++; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = !sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = !mack; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] wbuf [16];

  task automatic wait_ready;
    bit ack, first;
    int polls = 0;
    do begin
      i2c_start; send(CTRL_W, ack); i2c_stop;
      if (polls == 0) first = ack;
      polls++;
    end while (!ack && polls < 40);
    check(first == 1'b0, "R4 first poll refused", int'(first), 0);
    check(ack == 1'b1, "R4 poll accepted after cycle", int'(ack), 1);
  endtask

  task automatic write_page(input logic [7:0] base, input int n);
    bit ack;
    int c0 = commit_n;
    logic [7:0] a;
    wlog_n = 0;
    i2c_start;
    send(CTRL_W, ack); check(ack, "R3 write control ack", int'(ack), 1);
    send(base, ack);   check(ack, "R5 address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send(wbuf[i], ack); check(ack, "R5 data ack", int'(ack), 1);
    end
    i2c_stop;
    tick(4);
    check(wlog_n == n, "R5 strobe count", wlog_n, n);
    for (int i = 0; i < n && i < 64; i++) begin
      a = {base[7:4], 4'(base[3:0] + i)};
      check(wlog_a[i] == a, "R8 page address", int'(wlog_a[i]), int'(a));
      check(wlog_d[i] == wbuf[i], "R5 write data", int'(wlog_d[i]), int'(wbuf[i]));
      ref_mem[a] = wbuf[i];
    end
    check(commit_n == c0 + 1, "R7 commit on stop", commit_n, c0 + 1);
    exp_ptr = {base[7:4], 4'(base[3:0] + n)};
    wait_ready;
  endtask

  task automatic read_seq(input int n, input bit set_addr, input logic [7:0] addr);
    bit ack;
    logic [7:0] b;
    i2c_start;
    if (set_addr) begin
      send(CTRL_W, ack); send(addr, ack);
      check(ack, "R5 address ack before read", int'(ack), 1);
      exp_ptr = addr;
      i2c_start;
    end
    send(CTRL_R, ack); check(ack, "R3 read control ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv(i < n - 1, b);
      check(b == ref_mem[exp_ptr], "R9 read data", int'(b), int'(ref_mem[exp_ptr]));
      exp_ptr = exp_ptr + 8'd1;
    end
    check(sda_oe == 1'b0, "R9 released after NACK", int'(sda_oe), 0);
    i2c_stop;
  endtask

  bit done = 1'b0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    int c0;
    void'($urandom(32'd4821));
    for (int i = 0; i < 256; i++) begin
      env_mem[i] = init_val(i);
      ref_mem[i] = init_val(i);
      pend_v[i]  = 1'b0;
    end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; ack_inhibit = 1'b0;
    tick(5);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    check(wr_valid == 1'b0 && commit == 1'b0, "R1 strobes idle", int'({wr_valid, commit}), 0);
    read_seq(1, 1'b0, 8'h00);                   // R1: pointer starts at 00h

    for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'hC0 + i);
    write_page(8'h10, 3);
    read_seq(3, 1'b1, 8'h10);                   // R2 repeated Start gives random read
    read_seq(2, 1'b0, 8'h00);                   // R9 current address continues
    write_page(8'h3E, 4);                       // R8 page wrap
    read_seq(4, 1'b1, 8'h3E);
    read_seq(4, 1'b1, 8'hFE);                   // R9 FFh to 00h wrap

    // R3 chip-select mismatch, then ignored until Start
    wlog_n = 0;
    i2c_start; send({4'b1010, 3'b010, 1'b0}, ack);
    check(!ack, "R3 chip-select mismatch refused", int'(ack), 0);
    send(8'h55, ack);
    check(!ack, "R3 ignored until Start", int'(ack), 0);
    i2c_stop;
    check(wlog_n == 0, "R3 no write after mismatch", wlog_n, 0);
    i2c_start; send({4'b0110, CS, 1'b0}, ack);
    check(!ack, "R3 wrong code refused", int'(ack), 0);
    i2c_stop;

    // R6 inhibited data byte
    c0 = commit_n; wlog_n = 0;
    i2c_start; send(CTRL_W, ack); send(8'h20, ack);
    ack_inhibit = 1'b1;
    send(8'hAA, ack);
    ack_inhibit = 1'b0;
    check(!ack, "R6 inhibited byte refused", int'(ack), 0);
    i2c_stop; tick(4);
    check(wlog_n == 0, "R6 no strobe when inhibited", wlog_n, 0);
    check(commit_n == c0, "R7 no commit without data", commit_n, c0);
    read_seq(1, 1'b1, 8'h20);                   // R6 array unchanged

    // R7 repeated Start after data drops the commit
    c0 = commit_n;
    i2c_start; send(CTRL_W, ack); send(8'h50, ack); send(8'h77, ack);
    exp_ptr = 8'h51;
    i2c_start; send(CTRL_R, ack);
    recv(1'b0, b);
    check(b == ref_mem[8'h51], "R9 read after dropped write", int'(b), int'(ref_mem[8'h51]));
    exp_ptr = 8'h52;
    i2c_stop; tick(4);
    check(commit_n == c0, "R7 Start discards pending commit", commit_n, c0);
    read_seq(1, 1'b0, 8'h00);

    // constrained random mix
    for (int k = 0; k < 10; k++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) begin
        int n = $urandom_range(1, 5);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        write_page(8'($urandom), n);
      end else if (op == 1) begin
        read_seq($urandom_range(1, 4), 1'b1, 8'($urandom));
      end else begin
        read_seq($urandom_range(1, 3), 1'b0, 8'h00);
      end
    end

    check(viol_n == 0, "R10 drive changes only in SCL low after hold", viol_n, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule